// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank State Tracker

This block watches the command pins of a DDR2-style memory device from the device side. On every rising clock edge it registers chip select, the three command strobes (row strobe, column strobe, write enable), a two-bit bank number, a thirteen-bit address and the clock-enable input. It turns that cycle into a decoded command, and it keeps a record of which of the four banks currently hold an open row. It stores the opcodes written by mode-register cycles, and it follows the device's power state.

The power logic is a four-state machine. Its states are ACTIVE, ACT_PD (active power-down), PRE_PD (precharge power-down) and SELF_REF (self refresh). The transitions are:
- ENTER_ACT_PD: clock enable sampled low while a row is open.
- ENTER_PRE_PD: clock enable sampled low with all banks idle and no refresh command.
- ENTER_SREF: clock enable sampled low with all banks idle and a refresh command presented.
- EXIT_PD: clock enable sampled high at an edge while in either power-down state.
- EXIT_SREF: clock enable rising. This transition does not wait for a clock edge.

Commands take effect only in ACTIVE with clock enable high. Two sticky error flags report protocol misuse: one for bank-state violations, and one for clock enable dropping during a data burst.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: A cycle with `cs_n` sampled high is reported as NOP (`cmd` = 0) and changes no state, whatever the strobe levels.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as 011 Activate, 101 Read, 100 Write, 010 Precharge, 001 Refresh, 000 Mode-set, and anything else as NOP. The command is executed only when the power state is ACTIVE and `cke` is high at the edge. `cmd` shows the result from the cycle after that edge with the codes 0 NOP, 1 Activate, 2 Read, 3 Write, 4 Precharge, 5 Refresh, 6 Self-refresh entry, 7 Mode-set. A command that is not executed shows as NOP, except for self-refresh entry.
- R3: An executed Activate to an idle bank sets `bank_open[ba]` one cycle later.
- R4: An executed Precharge with `addr[10]` low clears only `bank_open[ba]`. With `addr[10]` high it clears every bit.
- R5: An executed Read or Write to an open bank with `addr[10]` high clears that bank's bit one cycle later. With `addr[10]` low the bank stays open.
- R6: An executed Mode-set copies `addr` into `mode_base` when `ba` = 0 and into `mode_ext` when `ba` = 1. A Mode-set with `ba` = 2 or 3 changes neither register.
- R7: From ACTIVE, `cke` sampled low moves `pwr_state` (0 ACTIVE, 1 ACT_PD, 2 PRE_PD, 3 SELF_REF) as follows: to 1 if any bank is open; to 3 if all banks are idle and a Refresh is presented, with `cmd` reporting 6; to 2 otherwise.
- R8: Either power-down state returns to ACTIVE at the first edge that samples `cke` high. SELF_REF reports ACTIVE as soon as `cke` is high, with no clock edge needed.
- R9: `rx_main_en` is high only in ACTIVE. `rx_clk_odt_en` is low only in SELF_REF.
- R10: `cke_burst_err` sets, and stays set until reset, when `cke` is sampled low at any of the `BURST_CYC` (default 4) edges that follow an executed Read or Write.
- R11: `proto_err` sets, and stays set until reset, on an executed Activate to an open bank or an executed Read or Write to an idle bank. The offending command leaves `bank_open` unchanged.
- R12: While reset is held, and after it is released: `cmd` = 0, `bank_open` = 0, both mode registers are 0, `pwr_state` = 0, both enable flags are 1, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank number |
| addr | input | 13 | Row/column address, bit 10 precharge-all / auto-precharge |
| cmd | output | 3 | Decoded command of the last edge |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| mode_base | output | 13 | Last base mode-register opcode |
| mode_ext | output | 13 | Last extended mode-register opcode |
| pwr_state | output | 2 | Power state |
| rx_main_en | output | 1 | Command, address and data input buffers enabled |
| rx_clk_odt_en | output | 1 | Clock and termination-control buffers enabled |
| proto_err | output | 1 | Sticky bank-protocol error |
| cke_burst_err | output | 1 | Sticky clock-enable-during-burst error |

## Verification
Some properties are checked on every cycle:
- deselect gives NOP;
- Read decodes correctly;
- Activate opens the named bank;
- precharge-all empties the bank map;
- entry into active power-down happens when it should;
- the enable flags agree with the power state;
- SELF_REF is never reported while clock enable is high;
- both error flags are sticky.

Other behaviour shows up only in the bench's scenarios:
- the order in which banks are opened and closed;
- mode-register routing;
- the choice between precharge power-down and self refresh;
- the burst window length;
- the immediate, edge-free self-refresh exit.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_SREF = 3'd6,
        CMD_MRS  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'd0,
        PS_ACT_PD   = 2'd1,
        PS_PRE_PD   = 2'd2,
        PS_SELF_REF = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e dec
);

    always_comb begin
        if (cs_n) begin
            dec = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  dec = CMD_ACT;
                3'b101:  dec = CMD_RD;
                3'b100:  dec = CMD_WR;
                3'b010:  dec = CMD_PRE;
                3'b001:  dec = CMD_REF;
                3'b000:  dec = CMD_MRS;
                default: dec = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
    import ddr2_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec,
    input  cmd_e                 cmd,
    input  logic [BA_W-1:0]      ba,
    input  logic                 ap_bit,
    output logic [NUM_BANKS-1:0] open_q,
    output logic                 viol
);

    logic tgt_open;
    assign tgt_open = open_q[ba];

    // A violating command is flagged and leaves the bank bit alone.
    always_comb begin
        viol = 1'b0;
        if (exec) begin
            if (cmd == CMD_ACT && tgt_open)
                viol = 1'b1;
            if ((cmd == CMD_RD || cmd == CMD_WR) && !tgt_open)
                viol = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
            end else if (exec) begin
                if (cmd == CMD_ACT && sel && !open_q[g])
                    open_q[g] <= 1'b1;
                else if (cmd == CMD_PRE && (ap_bit || sel))
                    open_q[g] <= 1'b0;
                else if ((cmd == CMD_RD || cmd == CMD_WR) && sel && ap_bit && open_q[g])
                    open_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ddr2_pwr_fsm.sv
module ddr2_pwr_fsm
    import ddr2_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  cmd_e dec,
    input  logic any_open,
    output pwr_e state_o,
    output logic exec,
    output logic sref_entry,
    output logic rx_main_en,
    output logic rx_clk_odt_en
);

    pwr_e ps_q, ps_d, eff;

    // Self-refresh exit is combinational on cke; every other move waits for an edge.
    assign eff = (ps_q == PS_SELF_REF && cke) ? PS_ACTIVE : ps_q;

    always_comb begin
        ps_d       = eff;
        sref_entry = 1'b0;
        unique case (eff)
            PS_ACTIVE: begin
                if (!cke) begin
                    if (dec == CMD_REF && !any_open) begin
                        ps_d       = PS_SELF_REF;
                        sref_entry = 1'b1;
                    end else if (any_open) begin
                        ps_d = PS_ACT_PD;
                    end else begin
                        ps_d = PS_PRE_PD;
                    end
                end
            end
            PS_ACT_PD, PS_PRE_PD: begin
                if (cke)
                    ps_d = PS_ACTIVE;
            end
            PS_SELF_REF: ps_d = PS_SELF_REF;
            default:     ps_d = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_q <= PS_ACTIVE;
        else
            ps_q <= ps_d;
    end

    always_comb begin
        state_o       = eff;
        exec          = (eff == PS_ACTIVE) && cke;
        rx_main_en    = (eff == PS_ACTIVE);
        rx_clk_odt_en = (eff != PS_SELF_REF);
    end

endmodule

// File: rtl/ddr2_burst_guard.sv
module ddr2_burst_guard #(
    parameter int BURST_CYC = 4,
    localparam int CNT_W = $clog2(BURST_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic start,
    output logic err_q
);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (left_q != '0 && !cke)
                err_q <= 1'b1;
            if (start)
                left_q <= CNT_W'(BURST_CYC);
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
    import ddr2_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int BURST_CYC = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [2:0]           cmd,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ADDR_W-1:0]    mode_base,
    output logic [ADDR_W-1:0]    mode_ext,
    output logic [1:0]           pwr_state,
    output logic                 rx_main_en,
    output logic                 rx_clk_odt_en,
    output logic                 proto_err,
    output logic                 cke_burst_err
);

    localparam logic [BA_W-1:0] SEL_BASE = BA_W'(0);
    localparam logic [BA_W-1:0] SEL_EXT  = BA_W'(1);

    cmd_e dec, cmd_q;
    pwr_e pstate;
    logic exec, sref_entry, viol;

    ddr2_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .dec   (dec)
    );

    ddr2_pwr_fsm u_pwr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cke           (cke),
        .dec           (dec),
        .any_open      (|bank_open),
        .state_o       (pstate),
        .exec          (exec),
        .sref_entry    (sref_entry),
        .rx_main_en    (rx_main_en),
        .rx_clk_odt_en (rx_clk_odt_en)
    );

    ddr2_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec   (exec),
        .cmd    (dec),
        .ba     (ba),
        .ap_bit (addr[AP_BIT]),
        .open_q (bank_open),
        .viol   (viol)
    );

    ddr2_burst_guard #(.BURST_CYC(BURST_CYC)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .start (exec && (dec == CMD_RD || dec == CMD_WR)),
        .err_q (cke_burst_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            mode_base <= '0;
            mode_ext  <= '0;
            proto_err <= 1'b0;
        end else begin
            if (exec)
                cmd_q <= dec;
            else if (sref_entry)
                cmd_q <= CMD_SREF;
            else
                cmd_q <= CMD_NOP;
            if (exec && dec == CMD_MRS && ba == SEL_BASE)
                mode_base <= addr;
            if (exec && dec == CMD_MRS && ba == SEL_EXT)
                mode_ext <= addr;
            if (viol)
                proto_err <= 1'b1;
        end
    end

    assign cmd       = cmd_q;
    assign pwr_state = pstate;

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic [ADDR_W-1:0]    addr,
    input logic [2:0]           cmd,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [1:0]           pwr_state,
    input logic                 rx_main_en,
    input logic                 rx_clk_odt_en,
    input logic                 proto_err,
    input logic                 cke_burst_err
);

    logic live;
    assign live = cke && (pwr_state == 2'd0) && !cs_n;

    p_desel_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> cmd == 3'd0);

    p_read_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ras_n && !cas_n && we_n) |=> cmd == 3'd2);

    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ras_n && cas_n && we_n) |=> bank_open[$past(ba)]);

    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ras_n && cas_n && !we_n && addr[AP_BIT]) |=> bank_open == '0);

    p_act_pd_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !cke && (|bank_open)) |=> pwr_state == 2'd1);

    p_sref_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> pwr_state != 2'd3);

    p_buf_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_main_en == (pwr_state == 2'd0)) && (rx_clk_odt_en == (pwr_state != 2'd3)));

    p_burst_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cke_burst_err |=> cke_burst_err);

    p_proto_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cke           (cke),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .ba            (ba),
    .addr          (addr),
    .cmd           (cmd),
    .bank_open     (bank_open),
    .pwr_state     (pwr_state),
    .rx_main_en    (rx_main_en),
    .rx_clk_odt_en (rx_clk_odt_en),
    .proto_err     (proto_err),
    .cke_burst_err (cke_burst_err)
);

// File: tb/ddr2_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr2_cmd_tracker_tb_top;

    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [2:0]  cmd;
    logic [3:0]  bank_open;
    logic [12:0] mode_base, mode_ext;
    logic [1:0]  pwr_state;
    logic        rx_main_en, rx_clk_odt_en, proto_err, cke_burst_err;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0]  m_cmd;
    logic [3:0]  m_open;
    logic [12:0] m_base, m_ext;
    logic [1:0]  m_ps;
    logic        m_perr, m_cerr;
    int          m_cnt;

    always #5 clk = ~clk;

    ddr2_cmd_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
        .bank_open(bank_open), .mode_base(mode_base), .mode_ext(mode_ext),
        .pwr_state(pwr_state), .rx_main_en(rx_main_en), .rx_clk_odt_en(rx_clk_odt_en),
        .proto_err(proto_err), .cke_burst_err(cke_burst_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] f_dec(input logic cs, ras, cas, we);
        if (cs) return 3'd0;
        case ({ras, cas, we})
            3'b011: return 3'd1;
            3'b101: return 3'd2;
            3'b100: return 3'd3;
            3'b010: return 3'd4;
            3'b001: return 3'd5;
            3'b000: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_open = 0; m_base = 0; m_ext = 0; m_ps = 0;
        m_perr = 0; m_cerr = 0; m_cnt = 0;
    endtask

    task automatic model_edge(input logic cs, ras, cas, we, input logic [1:0] b,
                              input logic [12:0] a, input logic ck);
        logic [2:0] d;
        logic ex, sref;
        logic [1:0] nps;
        d = f_dec(cs, ras, cas, we);
        ex = (m_ps == 2'd0) && ck;
        sref = (m_ps == 2'd0) && !ck && d == 3'd5 && m_open == 0;
        if (m_cnt != 0 && !ck) m_cerr = 1'b1;
        if (ex && (d == 3'd2 || d == 3'd3)) m_cnt = BL;
        else if (m_cnt != 0) m_cnt--;
        nps = m_ps;
        case (m_ps)
            2'd0: if (!ck) nps = sref ? 2'd3 : (m_open != 0 ? 2'd1 : 2'd2);
            2'd1, 2'd2: if (ck) nps = 2'd0;
            default: nps = m_ps;
        endcase
        m_cmd = ex ? d : (sref ? 3'd6 : 3'd0);
        if (ex) begin
            case (d)
                3'd1: if (m_open[b]) m_perr = 1'b1; else m_open[b] = 1'b1;
                3'd2, 3'd3: if (!m_open[b]) m_perr = 1'b1; else if (a[10]) m_open[b] = 1'b0;
                3'd4: if (a[10]) m_open = 0; else m_open[b] = 1'b0;
                3'd7: begin
                    if (b == 2'd0) m_base = a;
                    if (b == 2'd1) m_ext = a;
                end
                default: ;
            endcase
        end
        m_ps = nps;
    endtask

    task automatic compare_all();
        chk("R2 cmd", 32'(cmd), 32'(m_cmd));
        chk("R3/R4/R5 bank_open", 32'(bank_open), 32'(m_open));
        chk("R6 mode_base", 32'(mode_base), 32'(m_base));
        chk("R6 mode_ext", 32'(mode_ext), 32'(m_ext));
        chk("R7/R8 pwr_state", 32'(pwr_state), 32'(m_ps));
        chk("R9 buffer flags", 32'({rx_main_en, rx_clk_odt_en}),
            32'({m_ps == 2'd0, m_ps != 2'd3}));
        chk("R11 proto_err", 32'(proto_err), 32'(m_perr));
        chk("R10 cke_burst_err", 32'(cke_burst_err), 32'(m_cerr));
    endtask

    task automatic step(input logic cs, ras, cas, we, input logic [1:0] b,
                        input logic [12:0] a, input logic ck);
        @(negedge clk);
        cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; ba = b; addr = a; cke = ck;
        if (m_ps == 2'd3 && ck) begin
            m_ps = 2'd0;
            #1;
            // R8: self-refresh exit seen before any clock edge
            chk("R8 async sref exit", 32'(pwr_state), 32'd0);
            chk("R9 flags after sref exit", 32'({rx_main_en, rx_clk_odt_en}), 32'b11);
        end
        @(posedge clk);
        model_edge(cs, ras, cas, we, b, a, ck);
        #1;
        compare_all();
    endtask

    // shorthand steps
    task automatic nop(input logic ck);            step(0, 1, 1, 1, 0, 0, ck); endtask
    task automatic act(input logic [1:0] b);        step(0, 0, 1, 1, b, 13'h0123, 1); endtask
    task automatic rd(input logic [1:0] b, input logic ap); step(0, 1, 0, 1, b, 13'(ap) << 10, 1); endtask
    task automatic wr(input logic [1:0] b, input logic ap); step(0, 1, 0, 0, b, 13'(ap) << 10, 1); endtask
    task automatic pre(input logic [1:0] b, input logic all); step(0, 0, 1, 0, b, 13'(all) << 10, 1); endtask
    task automatic mrs(input logic [1:0] b, input logic [12:0] a); step(0, 0, 0, 0, b, a, 1); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
        model_reset();
        repeat (2) @(negedge clk);
        // R12: state while reset is held
        chk("R12 reset cmd/banks", 32'({cmd, bank_open}), 32'd0);
        chk("R12 reset modes", 32'({mode_base, mode_ext}), 32'd0);
        chk("R12 reset power/flags/errs",
            32'({pwr_state, rx_main_en, rx_clk_odt_en, proto_err, cke_burst_err}), 32'b001100);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset();
        nop(1);

        // R6: mode register routing, bank 2 ignored
        mrs(2'd0, 13'h00A5);
        mrs(2'd1, 13'h1234);
        mrs(2'd2, 13'h1FFF);
        chk("R6 ignored select", 32'({mode_base, mode_ext}), 32'({13'h00A5, 13'h1234}));

        // R3 and R11: open banks, re-activate an open one
        act(2'd1);
        act(2'd2);
        chk("R3 two banks open", 32'(bank_open), 32'b0110);
        act(2'd1);
        chk("R11 error on double activate", 32'({proto_err, bank_open}), 32'b10110);

        // R5: read with auto-precharge closes; burst with cke high is clean
        rd(2'd1, 1'b0);
        rd(2'd2, 1'b1);
        chk("R5 auto-precharge close", 32'(bank_open), 32'b0010);
        repeat (BL) nop(1);

        // R4: single and all-bank precharge
        pre(2'd1, 1'b0);
        chk("R4 single precharge", 32'(bank_open), 32'b0000);
        act(2'd0);
        act(2'd3);
        pre(2'd0, 1'b1);
        chk("R4 precharge all", 32'(bank_open), 32'b0000);

        // R1: deselected activate does nothing
        step(1, 0, 1, 1, 2'd3, 0, 1);
        chk("R1 deselect", 32'({cmd, bank_open}), 32'd0);

        // R7/R8: active power-down entry and exit
        act(2'd0);
        nop(0);
        chk("R7 active power-down", 32'(pwr_state), 32'd1);
        nop(0);
        nop(1);
        chk("R8 power-down exit", 32'(pwr_state), 32'd0);
        pre(2'd0, 1'b1);

        // R7: precharge power-down, then self refresh
        nop(0);
        chk("R7 precharge power-down", 32'(pwr_state), 32'd2);
        nop(1);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R7 self refresh entry", 32'({cmd, pwr_state}), 32'({3'd6, 2'd3}));
        nop(0);
        nop(0);
        nop(1);

        // R10: cke dropped during write burst
        act(2'd0);
        wr(2'd0, 1'b0);
        nop(1);
        nop(0);
        chk("R10 burst cke error", 32'(cke_burst_err), 32'd1);
        nop(1);

        // random phase
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic ck;
            if (m_ps == 2'd0) ck = ($urandom % 10) != 0;
            else ck = ($urandom % 3) == 0;
            step(($urandom % 6) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 13'($urandom), ck);
            if (($urandom % 40) == 0) begin
                step(0, 0, 1, 0, 0, 13'h0400, 1);
            end
        end

        finish_run();
    end

endmodule